// File: doc/BRIEF.md
# Sigma-Delta Converter Serial Register Port

This block is the device-side serial port of a sigma-delta converter's register file. An external host drives a four-wire serial bus in clock-polarity-high, sample-on-rising mode. Every transaction opens with an 8-bit command byte that picks read or write and one of eight register addresses. The chosen register is then shifted out or in at its own width, MSB first. DIN is sampled on rising SCLK edges and DOUT changes on falling SCLK edges. All serial inputs are brought into the system clock domain by synchronizer chains, so the system clock must run several times faster than SCLK.

A conversion source inside the chip presents finished samples on a one-cycle strobe. These samples fill the data register and the status byte. A host can stream conversions without resending commands by entering a continuous-read state. The host can realign a lost interface at any time by sending a long run of ones. The writable registers are exposed as ports so that the rest of the converter can use them.

Top module: `sdadc_spi_if`

## Requirements
- R1: After reset the outputs hold these values: mode 24'h080060, configuration 24'h000110, GPO 8'h00, offset 24'h800000, gain 24'h500000. DOUT is 1, stream_active is 0, and the status byte reads 8'h00.
- R2: The command byte uses this layout: bit 7 must be 0 for the byte to be accepted, bit 6 is 1 for read and 0 for write, bits 5:3 are the address, and bit 2 requests streaming. A byte with bit 7 set is discarded, and the next 8 bits are taken as a new command.
- R3: Addresses 1 (mode, 24 bits), 2 (configuration, 24 bits), 5 (GPO, 8 bits), 6 (offset, 24 bits) and 7 (gain, 24 bits) can be written. The new value takes effect only after the last payload bit. A write command to address 0, 3 or 4 carries no payload, and the next 8 bits are taken as a new command.
- R4: Reads return each register MSB first at its width: status, ID and GPO are 8 bits, the others 24 bits. The ID byte is {4'h0, ID_CODE}, and ID_CODE defaults to 4'h4.
- R5: The status byte is laid out as {ready, error, no-reference, parity, 0, channel[2:0]}. Parity is the XOR of the 24 data bits. Error, no-reference and channel are captured together with each conversion.
- R6: A conversion strobe sets ready. A completed read of the data register clears ready. If a strobe arrives in the same cycle as a completed read, the strobe wins.
- R7: When mode bit 20 is 1, a data read is 32 bits long: the 24-bit sample followed by the status byte.
- R8: A read command to address 3 with bit 2 set enters the streaming state, and stream_active goes to 1. In this state each frame returns the data register, captured at the first falling SCLK edge of that frame, with no command byte in front.
- R9: In the streaming state, if the first 8 DIN bits of a frame equal 8'h58, streaming ends right after that byte. The following 8 bits are then taken as a command.
- R10: Raising CS_n in the middle of a frame aborts it, and no register changes. Outside streaming the port then waits for a command. In streaming the next frame starts again from its first bit.
- R11: 48 consecutive rising SCLK edges with DIN high return the port to waiting for a command and end streaming. Register contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock, idles high |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host, registered |
| conv_valid | input | 1 | One-cycle strobe for a finished conversion |
| conv_word | input | 24 | Conversion result |
| conv_chan | input | 3 | Channel of the conversion |
| conv_err | input | 1 | Conversion error flag |
| conv_noref | input | 1 | Missing reference flag |
| mode_reg | output | 24 | Mode register |
| conf_reg | output | 24 | Configuration register |
| gpo_reg | output | 8 | General-purpose output control register |
| offset_reg | output | 24 | Offset coefficient register |
| gain_reg | output | 24 | Full-scale coefficient register |
| stream_active | output | 1 | Port is in the streaming state |

## Verification
The assertions assume that SCLK, CS_n and DIN change far enough apart in system-clock terms that the three synchronizers deliver each edge with its data. They also assume that conv_valid is a single-cycle strobe that can arrive at any time. The stimulus keeps each SCLK half period at eight system clocks and changes DIN together with the falling edge. It opens and closes CS_n only while SCLK is high. It raises a conversion only while SCLK is idle, and it waits for ready before it reads data in the streaming state.

// File: rtl/sdadc_spi_pkg.sv
package sdadc_spi_pkg;

  localparam int CMD_BITS  = 8;
  localparam int WORD_BITS = 24;
  localparam int TX_BITS   = 32;
  localparam int APPEND_BIT = 20;
  localparam logic [7:0] STREAM_EXIT = 8'h58;

  typedef enum logic [2:0] {
    RA_STAT = 3'd0,
    RA_MODE = 3'd1,
    RA_CONF = 3'd2,
    RA_DATA = 3'd3,
    RA_ID   = 3'd4,
    RA_GPO  = 3'd5,
    RA_OFFS = 3'd6,
    RA_GAIN = 3'd7
  } reg_addr_t;

  typedef enum logic [1:0] {
    FS_CMD,
    FS_WRITE,
    FS_READ,
    FS_STREAM
  } frame_state_t;

  // Payload length in bits for an address; data grows when status is appended.
  function automatic int frame_bits(input logic [2:0] a, input logic append);
    case (a)
      RA_STAT, RA_ID, RA_GPO: frame_bits = CMD_BITS;
      RA_DATA:                frame_bits = append ? TX_BITS : WORD_BITS;
      default:                frame_bits = WORD_BITS;
    endcase
  endfunction

  function automatic logic writable(input logic [2:0] a);
    case (a)
      RA_MODE, RA_CONF, RA_GPO, RA_OFFS, RA_GAIN: writable = 1'b1;
      default:                                    writable = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/sdadc_spi_sync.sv
module sdadc_spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], async_in};
  end

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/sdadc_spi_regs.sv
module sdadc_spi_regs
  import sdadc_spi_pkg::*;
#(
  parameter logic [3:0]           ID_CODE  = 4'h4,
  parameter logic [WORD_BITS-1:0] MODE_RST = 24'h080060,
  parameter logic [WORD_BITS-1:0] CONF_RST = 24'h000110,
  parameter logic [WORD_BITS-1:0] OFFS_RST = 24'h800000,
  parameter logic [WORD_BITS-1:0] GAIN_RST = 24'h500000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [2:0]           wr_addr,
  input  logic [WORD_BITS-1:0] wr_data,
  input  logic                 taken,
  input  logic                 conv_valid,
  input  logic [WORD_BITS-1:0] conv_word,
  input  logic [2:0]           conv_chan,
  input  logic                 conv_err,
  input  logic                 conv_noref,
  input  logic [2:0]           rd_addr,
  output logic [TX_BITS-1:0]   rd_word,
  output logic [WORD_BITS-1:0] mode_q,
  output logic [WORD_BITS-1:0] conf_q,
  output logic [7:0]           gpo_q,
  output logic [WORD_BITS-1:0] offs_q,
  output logic [WORD_BITS-1:0] gain_q,
  output logic [7:0]           status_q,
  output logic                 append
);

  localparam int PAD = TX_BITS - WORD_BITS;
  localparam int BPAD = TX_BITS - CMD_BITS;

  logic [WORD_BITS-1:0] data_q;
  logic                 ready_q, err_q, noref_q, par_q;
  logic [2:0]           chan_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_RST;
      conf_q  <= CONF_RST;
      gpo_q   <= '0;
      offs_q  <= OFFS_RST;
      gain_q  <= GAIN_RST;
      data_q  <= '0;
      ready_q <= 1'b0;
      err_q   <= 1'b0;
      noref_q <= 1'b0;
      par_q   <= 1'b0;
      chan_q  <= '0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          RA_MODE: mode_q <= wr_data;
          RA_CONF: conf_q <= wr_data;
          RA_GPO:  gpo_q  <= wr_data[7:0];
          RA_OFFS: offs_q <= wr_data;
          RA_GAIN: gain_q <= wr_data;
          default: ;
        endcase
      end
      if (conv_valid) begin
        data_q  <= conv_word;
        ready_q <= 1'b1;
        err_q   <= conv_err;
        noref_q <= conv_noref;
        par_q   <= ^conv_word;
        chan_q  <= conv_chan;
      end else if (taken) begin
        ready_q <= 1'b0;
      end
    end
  end

  assign status_q = {ready_q, err_q, noref_q, par_q, 1'b0, chan_q};
  assign append   = mode_q[APPEND_BIT];

  // Left-aligned readback so the frame logic always shifts from bit TX_BITS-1.
  always_comb begin
    case (reg_addr_t'(rd_addr))
      RA_STAT: rd_word = {status_q, {BPAD{1'b0}}};
      RA_MODE: rd_word = {mode_q, {PAD{1'b0}}};
      RA_CONF: rd_word = {conf_q, {PAD{1'b0}}};
      RA_DATA: rd_word = {data_q, status_q};
      RA_ID:   rd_word = {4'h0, ID_CODE, {BPAD{1'b0}}};
      RA_GPO:  rd_word = {gpo_q, {BPAD{1'b0}}};
      RA_OFFS: rd_word = {offs_q, {PAD{1'b0}}};
      default: rd_word = {gain_q, {PAD{1'b0}}};
    endcase
  end

endmodule

// File: rtl/sdadc_spi_frame.sv
module sdadc_spi_frame
  import sdadc_spi_pkg::*;
#(
  parameter int ONES_LIMIT = 48
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sclk_s,
  input  logic                 cs_n_s,
  input  logic                 din_s,
  input  logic [TX_BITS-1:0]   rd_word,
  input  logic                 append,
  output logic [2:0]           rd_addr,
  output logic                 wr_en,
  output logic [2:0]           wr_addr,
  output logic [WORD_BITS-1:0] wr_data,
  output logic                 taken,
  output logic                 dout,
  output logic                 stream_on
);

  localparam int CNT_W  = $clog2(TX_BITS + 1);
  localparam int IDX_W  = $clog2(TX_BITS);
  localparam int ONES_W = $clog2(ONES_LIMIT + 1);

  frame_state_t         st;
  logic [CNT_W-1:0]     cnt, len;
  logic [WORD_BITS-1:0] rx;
  logic [TX_BITS-1:0]   tx;
  logic [2:0]           addr_q;
  logic [ONES_W-1:0]    ones;
  logic                 sclk_d;
  logic                 rise, fall, last_bit, ones_hit;
  logic [7:0]           byte_in;
  logic [IDX_W-1:0]     tx_sel;

  assign rise     = sclk_s & ~sclk_d;
  assign fall     = ~sclk_s & sclk_d;
  assign byte_in  = {rx[6:0], din_s};
  assign last_bit = (cnt == len - CNT_W'(1));
  assign ones_hit = din_s && (ones == ONES_W'(ONES_LIMIT - 1));
  assign tx_sel   = IDX_W'(TX_BITS - 1) - IDX_W'(cnt);
  assign rd_addr  = (st == FS_STREAM) ? RA_DATA : rx[4:2];
  assign stream_on = (st == FS_STREAM);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= FS_CMD;
      cnt     <= '0;
      len     <= CNT_W'(CMD_BITS);
      rx      <= '0;
      tx      <= '0;
      addr_q  <= '0;
      ones    <= '0;
      sclk_d  <= 1'b1;
      dout    <= 1'b1;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      taken   <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      wr_en  <= 1'b0;
      taken  <= 1'b0;
      if (cs_n_s) begin
        cnt  <= '0;
        ones <= '0;
        if (st != FS_STREAM) st <= FS_CMD;
      end else if (rise) begin
        rx   <= {rx[WORD_BITS-2:0], din_s};
        ones <= din_s ? ones + ONES_W'(1) : '0;
        if (ones_hit) begin
          st   <= FS_CMD;
          cnt  <= '0;
          ones <= '0;
        end else begin
          case (st)
            FS_CMD: begin
              if (cnt == CNT_W'(CMD_BITS - 1)) begin
                cnt    <= '0;
                addr_q <= byte_in[5:3];
                len    <= CNT_W'(frame_bits(byte_in[5:3], append));
                if (!byte_in[7]) begin
                  if (byte_in[6]) begin
                    if (byte_in[2] && (byte_in[5:3] == RA_DATA)) begin
                      st <= FS_STREAM;
                    end else begin
                      st <= FS_READ;
                      tx <= rd_word;
                    end
                  end else if (writable(byte_in[5:3])) begin
                    st <= FS_WRITE;
                  end
                end
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            FS_WRITE: begin
              if (last_bit) begin
                wr_en   <= 1'b1;
                wr_addr <= addr_q;
                wr_data <= {rx[WORD_BITS-2:0], din_s};
                st      <= FS_CMD;
                cnt     <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            FS_READ: begin
              if (last_bit) begin
                taken <= (addr_q == RA_DATA);
                st    <= FS_CMD;
                cnt   <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
            default: begin
              if ((cnt == CNT_W'(CMD_BITS - 1)) && (byte_in == STREAM_EXIT)) begin
                st  <= FS_CMD;
                cnt <= '0;
              end else if (last_bit) begin
                taken <= 1'b1;
                cnt   <= '0;
              end else begin
                cnt <= cnt + CNT_W'(1);
              end
            end
          endcase
        end
      end else if (fall) begin
        case (st)
          FS_READ: dout <= tx[tx_sel];
          FS_STREAM: begin
            if (cnt == '0) begin
              tx   <= rd_word;
              len  <= CNT_W'(frame_bits(RA_DATA, append));
              dout <= rd_word[TX_BITS-1];
            end else begin
              dout <= tx[tx_sel];
            end
          end
          default: dout <= 1'b1;
        endcase
      end
    end
  end

endmodule

// File: rtl/sdadc_spi_if.sv
module sdadc_spi_if
  import sdadc_spi_pkg::*;
#(
  parameter int                   SYNC_STAGES = 2,
  parameter int                   ONES_LIMIT  = 48,
  parameter logic [3:0]           ID_CODE     = 4'h4,
  parameter logic [WORD_BITS-1:0] MODE_RST    = 24'h080060,
  parameter logic [WORD_BITS-1:0] CONF_RST    = 24'h000110,
  parameter logic [WORD_BITS-1:0] OFFS_RST    = 24'h800000,
  parameter logic [WORD_BITS-1:0] GAIN_RST    = 24'h500000
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 spi_sclk,
  input  logic                 spi_cs_n,
  input  logic                 spi_mosi,
  output logic                 spi_miso,
  input  logic                 conv_valid,
  input  logic [WORD_BITS-1:0] conv_word,
  input  logic [2:0]           conv_chan,
  input  logic                 conv_err,
  input  logic                 conv_noref,
  output logic [WORD_BITS-1:0] mode_reg,
  output logic [WORD_BITS-1:0] conf_reg,
  output logic [7:0]           gpo_reg,
  output logic [WORD_BITS-1:0] offset_reg,
  output logic [WORD_BITS-1:0] gain_reg,
  output logic                 stream_active
);

  localparam int N_SYNC = 3;
  // Index 0: serial clock (idles high), 1: select (idles high), 2: data.
  localparam logic [N_SYNC-1:0] SYNC_RST = 3'b011;

  logic [N_SYNC-1:0]    raw_in, synced;
  logic [2:0]           rd_addr, wr_addr;
  logic [TX_BITS-1:0]   rd_word;
  logic                 wr_en, taken, append;
  logic [WORD_BITS-1:0] wr_data;
  logic [7:0]           status_q;
  logic                 cs_q;

  assign raw_in = {spi_mosi, spi_cs_n, spi_sclk};
  assign cs_q   = synced[1];

  for (genvar g = 0; g < N_SYNC; g++) begin : g_sync
    sdadc_spi_sync #(
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST[g])
    ) u_sync (
      .clk     (clk),
      .rst     (rst),
      .async_in(raw_in[g]),
      .sync_out(synced[g])
    );
  end

  sdadc_spi_frame #(
    .ONES_LIMIT(ONES_LIMIT)
  ) u_frame (
    .clk      (clk),
    .rst      (rst),
    .sclk_s   (synced[0]),
    .cs_n_s   (cs_q),
    .din_s    (synced[2]),
    .rd_word  (rd_word),
    .append   (append),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .taken    (taken),
    .dout     (spi_miso),
    .stream_on(stream_active)
  );

  sdadc_spi_regs #(
    .ID_CODE (ID_CODE),
    .MODE_RST(MODE_RST),
    .CONF_RST(CONF_RST),
    .OFFS_RST(OFFS_RST),
    .GAIN_RST(GAIN_RST)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .taken     (taken),
    .conv_valid(conv_valid),
    .conv_word (conv_word),
    .conv_chan (conv_chan),
    .conv_err  (conv_err),
    .conv_noref(conv_noref),
    .rd_addr   (rd_addr),
    .rd_word   (rd_word),
    .mode_q    (mode_reg),
    .conf_q    (conf_reg),
    .gpo_q     (gpo_reg),
    .offs_q    (offset_reg),
    .gain_q    (gain_reg),
    .status_q  (status_q),
    .append    (append)
  );

endmodule

// File: rtl/sdadc_spi_if_chk.sv
module sdadc_spi_if_chk (
  input logic        clk,
  input logic        rst,
  input logic        cs_n_s,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic        taken,
  input logic        conv_valid,
  input logic        ready,
  input logic [23:0] mode_q
);

  p_wr_target_r3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr == 3'd1 || wr_addr == 3'd2 || wr_addr == 3'd5 ||
               wr_addr == 3'd6 || wr_addr == 3'd7));

  p_mode_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && wr_addr == 3'd1) |=> $stable(mode_q));

  p_no_write_deselected_r10: assert property (@(posedge clk) disable iff (rst)
    $past(cs_n_s) |-> !wr_en);

  p_ready_set_r6: assert property (@(posedge clk) disable iff (rst)
    conv_valid |=> ready);

  p_ready_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (taken && !conv_valid) |=> !ready);

  p_ready_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!taken && !conv_valid) |=> $stable(ready));

endmodule

bind sdadc_spi_if sdadc_spi_if_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n_s    (cs_q),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .taken     (taken),
  .conv_valid(conv_valid),
  .ready     (status_q[7]),
  .mode_q    (mode_reg)
);

// File: tb/sdadc_spi_if_bench.sv
module sdadc_spi_if_bench;

  localparam int HALF = 8;
  localparam logic [3:0] IDC = 4'h4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b1, cs_n = 1'b1, din = 1'b0;
  logic        miso;
  logic        cv = 1'b0;
  logic [23:0] cw = '0;
  logic [2:0]  cc = '0;
  logic        ce = 1'b0, cn = 1'b0;
  logic [23:0] mode_o, conf_o, offs_o, gain_o;
  logic [7:0]  gpo_o;
  logic        strm;

  int n_chk = 0, n_fail = 0, quiet = 0;
  bit done = 1'b0;

  // Behavioural mirror of the writable registers.
  logic [23:0] m_mode = 24'h080060, m_conf = 24'h000110, m_offs = 24'h800000, m_gain = 24'h500000;
  logic [7:0]  m_gpo = 8'h00;

  always #5 clk = ~clk;

  sdadc_spi_if u_sdadc_spi_if (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(din), .spi_miso(miso),
    .conv_valid(cv), .conv_word(cw), .conv_chan(cc), .conv_err(ce), .conv_noref(cn),
    .mode_reg(mode_o), .conf_reg(conf_o), .gpo_reg(gpo_o), .offset_reg(offs_o),
    .gain_reg(gain_o), .stream_active(strm)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Per-clock comparison of register outputs against the mirror while idle.
  always @(negedge clk) begin
    if (rst || !cs_n) quiet <= 0;
    else quiet <= quiet + 1;
    if (!rst && cs_n && quiet >= 8 && !done) begin
      chk("R3 mirror mode", {8'h0, mode_o}, {8'h0, m_mode});
      chk("R3 mirror conf", {8'h0, conf_o}, {8'h0, m_conf});
      chk("R3 mirror gpo", {24'h0, gpo_o}, {24'h0, m_gpo});
      chk("R3 mirror offs", {8'h0, offs_o}, {8'h0, m_offs});
      chk("R3 mirror gain", {8'h0, gain_o}, {8'h0, m_gain});
    end
  end

  task automatic half();
    repeat (HALF) @(posedge clk);
    #1;
  endtask

  task automatic xfer(input int n, input logic [31:0] mosi, output logic [31:0] got);
    got = '0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      din  = mosi[n-1-i];
      half();
      got  = {got[30:0], miso};
      sclk = 1'b1;
      half();
    end
  endtask

  task automatic cs_begin();
    cs_n = 1'b0;
    half();
  endtask

  task automatic cs_end();
    half();
    cs_n = 1'b1;
    din  = 1'b0;
    half();
    half();
  endtask

  function automatic logic [7:0] cmd(input logic rd, input logic [2:0] a, input logic st);
    return {1'b0, rd, a, st, 2'b00};
  endfunction

  task automatic wr_reg(input logic [2:0] a, input int n, input logic [23:0] v);
    logic [31:0] g;
    cs_begin();
    xfer(8, {24'h0, cmd(1'b0, a, 1'b0)}, g);
    xfer(n, {8'h0, v}, g);
    case (a)
      3'd1: m_mode = v;
      3'd2: m_conf = v;
      3'd5: m_gpo  = v[7:0];
      3'd6: m_offs = v;
      3'd7: m_gain = v;
      default: ;
    endcase
    cs_end();
  endtask

  task automatic rd_reg(input logic [2:0] a, input int n, output logic [31:0] v);
    logic [31:0] g;
    cs_begin();
    xfer(8, {24'h0, cmd(1'b1, a, 1'b0)}, g);
    xfer(n, 32'h0, v);
    cs_end();
  endtask

  task automatic convert(input logic [23:0] w, input logic [2:0] ch, input logic e, input logic nr);
    @(posedge clk); #1;
    cv = 1'b1; cw = w; cc = ch; ce = e; cn = nr;
    @(posedge clk); #1;
    cv = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  function automatic logic [7:0] stat(input logic rdy, input logic [23:0] w, input logic [2:0] ch,
                                      input logic e, input logic nr);
    return {rdy, e, nr, ^w, 1'b0, ch};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, g;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 mode", {8'h0, mode_o}, 32'h080060);
    chk("R1 conf", {8'h0, conf_o}, 32'h000110);
    chk("R1 gpo", {24'h0, gpo_o}, 32'h0);
    chk("R1 offs", {8'h0, offs_o}, 32'h800000);
    chk("R1 gain", {8'h0, gain_o}, 32'h500000);
    chk("R1 miso idle", {31'h0, miso}, 32'h1);
    chk("R1 stream", {31'h0, strm}, 32'h0);
    rd_reg(3'd0, 8, v);
    chk("R1 R5 status after reset", v, 32'h00);

    // R4 identity byte
    rd_reg(3'd4, 8, v);
    chk("R4 id", v, {28'h0, IDC});

    // R3 / R4 writes and readback at each width
    wr_reg(3'd1, 24, 24'h0A1234);
    rd_reg(3'd1, 24, v);  chk("R4 mode read", v, 32'h0A1234);
    wr_reg(3'd2, 24, 24'h5A5A5A);
    rd_reg(3'd2, 24, v);  chk("R4 conf read", v, 32'h5A5A5A);
    wr_reg(3'd5, 8, 24'h0000C3);
    rd_reg(3'd5, 8, v);   chk("R4 gpo read", v, 32'hC3);
    chk("R3 gpo port", {24'h0, gpo_o}, 32'hC3);
    wr_reg(3'd6, 24, 24'h123456);
    rd_reg(3'd6, 24, v);  chk("R4 offs read", v, 32'h123456);
    wr_reg(3'd7, 24, 24'hFEDCBA);
    rd_reg(3'd7, 24, v);  chk("R4 gain read", v, 32'hFEDCBA);

    // R2 byte with bit 7 set is dropped; next byte is a command
    cs_begin();
    xfer(8, 32'h88, g);
    xfer(8, {24'h0, cmd(1'b1, 3'd4, 1'b0)}, g);
    xfer(8, 32'h0, v);
    cs_end();
    chk("R2 realign after bit7 byte", v, {28'h0, IDC});
    chk("R2 mode untouched", {8'h0, mode_o}, 32'h0A1234);

    // R3 write to read-only addresses carries no payload
    cs_begin();
    xfer(8, {24'h0, cmd(1'b0, 3'd4, 1'b0)}, g);
    xfer(8, {24'h0, cmd(1'b0, 3'd0, 1'b0)}, g);
    xfer(8, {24'h0, cmd(1'b1, 3'd4, 1'b0)}, g);
    xfer(8, 32'h0, v);
    cs_end();
    chk("R3 read-only write dropped", v, {28'h0, IDC});

    // R5 / R6 status capture, parity, ready clear
    convert(24'hABCDE0, 3'd5, 1'b1, 1'b0);
    rd_reg(3'd0, 8, v);
    chk("R5 status fields", v, {24'h0, stat(1'b1, 24'hABCDE0, 3'd5, 1'b1, 1'b0)});
    rd_reg(3'd3, 24, v);
    chk("R6 data read", v, 32'hABCDE0);
    rd_reg(3'd0, 8, v);
    chk("R6 ready cleared", v, {24'h0, stat(1'b0, 24'hABCDE0, 3'd5, 1'b1, 1'b0)});

    // R7 appended status
    wr_reg(3'd1, 24, 24'h1A1234);
    convert(24'h00F00F, 3'd2, 1'b0, 1'b1);
    rd_reg(3'd3, 32, v);
    chk("R7 data plus status", v, {24'h00F00F, stat(1'b1, 24'h00F00F, 3'd2, 1'b0, 1'b1)});
    rd_reg(3'd0, 8, v);
    chk("R7 R6 ready cleared after long read", v[7:0], 32'h0 | {24'h0, stat(1'b0, 24'h00F00F, 3'd2, 1'b0, 1'b1)});
    wr_reg(3'd1, 24, 24'h0A1234);

    // R8 / R9 streaming
    cs_begin();
    xfer(8, {24'h0, cmd(1'b1, 3'd3, 1'b1)}, g);
    chk("R8 stream entered", {31'h0, strm}, 32'h1);
    convert(24'h13579B, 3'd1, 1'b0, 1'b0);
    xfer(24, 32'h0, v);
    chk("R8 stream frame 1", v, 32'h13579B);
    convert(24'h2468AC, 3'd1, 1'b0, 1'b0);
    xfer(24, 32'h0, v);
    chk("R8 stream frame 2", v, 32'h2468AC);
    xfer(8, {24'h0, 8'h58}, g);
    xfer(8, {24'h0, cmd(1'b1, 3'd4, 1'b0)}, g);
    xfer(8, 32'h0, v);
    chk("R9 command after exit byte", v, {28'h0, IDC});
    chk("R9 stream left", {31'h0, strm}, 32'h0);
    cs_end();

    // R10 abort in streaming restarts the frame
    cs_begin();
    xfer(8, {24'h0, cmd(1'b1, 3'd3, 1'b1)}, g);
    convert(24'h0F1E2D, 3'd3, 1'b0, 1'b0);
    xfer(10, 32'h0, g);
    cs_end();
    chk("R10 stream kept across deselect", {31'h0, strm}, 32'h1);
    cs_begin();
    xfer(24, 32'h0, v);
    chk("R10 frame restarted", v, 32'h0F1E2D);
    xfer(8, {24'h0, 8'h58}, g);
    cs_end();

    // R10 aborted write leaves register unchanged
    cs_begin();
    xfer(8, {24'h0, cmd(1'b0, 3'd2, 1'b0)}, g);
    xfer(12, 32'hFFF, g);
    cs_end();
    rd_reg(3'd2, 24, v);
    chk("R10 aborted write", v, 32'h5A5A5A);

    // R11 48 ones realign from a partial command
    cs_begin();
    xfer(3, 32'h2, g);
    xfer(24, 32'hFFFFFF, g);
    xfer(24, 32'hFFFFFF, g);
    xfer(8, {24'h0, cmd(1'b1, 3'd4, 1'b0)}, g);
    xfer(8, 32'h0, v);
    cs_end();
    chk("R11 realign after ones", v, {28'h0, IDC});

    // R11 ones leave streaming, registers kept
    cs_begin();
    xfer(8, {24'h0, cmd(1'b1, 3'd3, 1'b1)}, g);
    xfer(24, 32'hFFFFFF, g);
    xfer(24, 32'hFFFFFF, g);
    chk("R11 stream left by ones", {31'h0, strm}, 32'h0);
    xfer(8, {24'h0, cmd(1'b1, 3'd1, 1'b0)}, g);
    xfer(24, 32'h0, v);
    cs_end();
    chk("R11 mode kept", v, 32'h0A1234);

    repeat (20) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule